// File: doc/BRIEF.md
# Interrupt CPU Target Register Bank

This block stores, for every interrupt in a parameterised range, an 8-bit mask with one bit per CPU that says which CPUs the interrupt is aimed at. Software reaches the masks through a simple register bus. Each 32-bit word of the bank covers four consecutive interrupts, one byte each. Byte strobes let a single access touch one interrupt or all four.

The first 32 interrupts are private to each CPU. Their masks are not stored here. They come in as a fixed input vector, read back through the bus like the other masks, and cannot be changed by bus writes. Every shared interrupt (number 32 and above) keeps a writable mask. Each write to that mask also updates a registered routed-CPU index, which is the position of the lowest set bit of the new mask, or zero when the mask is empty. The routed indices of all shared interrupts leave the block on one flat output. An interrupt delivery stage downstream uses them.

Top module: `itr_target_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every shared mask and every routed-CPU index is cleared to zero from that edge on, and `bus_rdata` reads zero.
- R2: Word address `w` (`bus_addr`) covers interrupts 4w to 4w+3. Byte lane i (`bus_wdata`/`bus_rdata` bits 8i+7..8i) belongs to interrupt 4w+i.
- R3: On a write (`bus_wr` high at a rising edge), only the lanes whose `bus_be` bit is set are stored. A single strobe bit gives a byte access, and all four give a word access.
- R4: Interrupts 0 to 31 (word addresses 0 to 7) read back their bytes from `priv_targets`, where interrupt k uses bits 8k+7..8k. Bus writes to them are ignored.
- R5: After a write to a shared interrupt's lane, `route_cpu` for that interrupt holds, from the next clock edge, the index of the lowest set bit of the written byte.
- R6: A shared interrupt whose written mask is zero gets routed-CPU index 0.
- R7: `bus_rd` high at a rising edge loads `bus_rdata` with the word at `bus_addr`, and the value is held until the next read. A read in the same cycle as a write to the same word returns the contents from before the write.
- R8: Word addresses at or above NUM_IRQ/4 read as zero, and writes to them change no stored mask.
- R9: The routed-CPU index of interrupt k (k >= 32) sits at `route_cpu` bits 3(k-32)+2..3(k-32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word address, four interrupts per word |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_be | input | 4 | Byte strobes for a write |
| bus_wdata | input | 32 | Write data, one mask byte per lane |
| bus_rdata | output | 32 | Registered read data |
| priv_targets | input | 256 | Fixed masks of interrupts 0 to 31, 8 bits each |
| route_cpu | output | 3*(NUM_IRQ-32) | Routed CPU index for each shared interrupt |

## Verification
The hardest case to reach is a write whose byte strobes cover only some lanes of a word while the other lanes still hold earlier values. The same applies to a read and a write that hit one word in the same cycle. Random stimulus is limited to a small address window that spans the private words, the shared words and a few words out of range. It uses random strobe patterns and random overlapping reads, so partial updates pile up on top of each other. Directed cases add single-bit masks at both ends, zero masks, and a read and write of the same word in the same cycle. After each operation, every routed index is compared with the lowest set bit computed by the bench.

// File: rtl/itr_pkg.sv
// Shared constants and helpers for the interrupt target bank.
// Assumes eight CPUs, so a mask is one byte and an index is three bits.
package itr_pkg;
    localparam int CPU_N   = 8;
    localparam int CPU_W   = $clog2(CPU_N);
    localparam int PRIV_N  = 32;
    localparam int LANES   = 4;
    localparam int BUS_W   = LANES * CPU_N;

    // Index of the lowest set bit; zero for an empty mask.
    function automatic logic [CPU_W-1:0] lowest_set(input logic [CPU_N-1:0] m);
        lowest_set = '0;
        for (int b = CPU_N - 1; b >= 0; b--) begin
            if (m[b]) lowest_set = CPU_W'(b);
        end
    endfunction
endpackage

// File: rtl/itr_entry.sv
// One shared interrupt: holds its CPU mask and the routed CPU index.
// Assumes the write hit is already decoded by the parent.
module itr_entry
    import itr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [CPU_N-1:0] wr_byte,
    output logic [CPU_N-1:0] mask,
    output logic [CPU_W-1:0] route
);
    // Store the mask and its lowest-bit route on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask  <= '0;
            route <= '0;
        end else if (wr_hit) begin
            mask  <= wr_byte;
            route <= lowest_set(wr_byte);
        end
    end
endmodule

// File: rtl/itr_read_port.sv
// Registered read port: selects one packed word of masks, zero out of range.
// Assumes NUM_IRQ/4 words fit in the ADDR_W-bit word address.
module itr_read_port
    import itr_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int ADDR_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        word_idx,
    input  logic [NUM_IRQ*CPU_N-1:0] all_masks,
    output logic [BUS_W-1:0]         rdata
);
    localparam int WORDS = NUM_IRQ / LANES;

    logic [BUS_W-1:0] sel;

    // Pick the addressed word; addresses past the bank give zero.
    always_comb begin
        sel = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (word_idx == ADDR_W'(w)) sel = all_masks[w*BUS_W +: BUS_W];
        end
    end

    // Capture read data on a read request and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= sel;
    end
endmodule

// File: rtl/itr_target_bank.sv
// Interrupt CPU target bank: per-interrupt 8-bit CPU masks on a register
// bus, fixed private masks for interrupts 0..31, a lowest-bit routed CPU
// index per shared interrupt. Assumes NUM_IRQ is a multiple of 32 and > 32.
module itr_target_bank
    import itr_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int ADDR_W  = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic                               bus_wr,
    input  logic                               bus_rd,
    input  logic [LANES-1:0]                   bus_be,
    input  logic [BUS_W-1:0]                   bus_wdata,
    output logic [BUS_W-1:0]                   bus_rdata,
    input  logic [PRIV_N*CPU_N-1:0]            priv_targets,
    output logic [(NUM_IRQ-PRIV_N)*CPU_W-1:0]  route_cpu
);
    localparam int NUM_SHARED = NUM_IRQ - PRIV_N;

    if ((NUM_IRQ % PRIV_N) != 0 || NUM_IRQ <= PRIV_N) begin : g_bad_size
        $error("NUM_IRQ must be a multiple of 32 above 32");
    end

    logic [NUM_IRQ*CPU_N-1:0] all_masks;

    // Private masks come straight from the fixed input.
    assign all_masks[PRIV_N*CPU_N-1:0] = priv_targets;

    for (genvar k = 0; k < NUM_SHARED; k++) begin : g_shared
        localparam int IRQ  = PRIV_N + k;
        localparam int LANE = IRQ % LANES;
        localparam int WORD = IRQ / LANES;
        logic hit;

        // Decode a write that lands on this interrupt's lane.
        assign hit = bus_wr && bus_be[LANE] && (bus_addr == ADDR_W'(WORD));

        itr_entry u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (hit),
            .wr_byte (bus_wdata[LANE*CPU_N +: CPU_N]),
            .mask    (all_masks[IRQ*CPU_N +: CPU_N]),
            .route   (route_cpu[k*CPU_W +: CPU_W])
        );
    end

    itr_read_port #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_rd),
        .word_idx  (bus_addr),
        .all_masks (all_masks),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/itr_target_bank_chk.sv
// Checker for the target bank: reset, routing, read and range properties.
// Assumes the same parameters as the bound instance.
module itr_target_bank_chk
    import itr_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int ADDR_W  = 8
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic [ADDR_W-1:0]                  bus_addr,
    input logic                               bus_wr,
    input logic                               bus_rd,
    input logic [BUS_W-1:0]                   bus_rdata,
    input logic [PRIV_N*CPU_N-1:0]            priv_targets,
    input logic [(NUM_IRQ-PRIV_N)*CPU_W-1:0]  route_cpu,
    input logic [NUM_IRQ*CPU_N-1:0]           all_masks
);
    localparam int WORDS = NUM_IRQ / LANES;
    localparam int NSH   = NUM_IRQ - PRIV_N;

    // R1: reset empties shared masks and routes
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (all_masks[NUM_IRQ*CPU_N-1:PRIV_N*CPU_N] == '0) && (route_cpu == '0));

    // R4: first private word reads the fixed input
    a_r4_priv_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (bus_addr == '0) |=> bus_rdata == $past(priv_targets[BUS_W-1:0]));

    // R7: read data holds without a read request
    a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R8: out-of-range reads give zero
    a_r8_oor_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (int'(bus_addr) >= WORDS) |=> bus_rdata == '0);

    // R8: out-of-range writes leave every mask unchanged
    a_r8_oor_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (int'(bus_addr) >= WORDS) |=> $stable(all_masks));

    for (genvar k = 0; k < NSH; k++) begin : g_route
        logic [CPU_N-1:0] m;
        logic [CPU_W-1:0] r;
        assign m = all_masks[(PRIV_N+k)*CPU_N +: CPU_N];
        assign r = route_cpu[k*CPU_W +: CPU_W];

        // R5: route points at a set bit with nothing set below it
        a_r5_route_lowest: assert property (@(posedge clk) disable iff (!rst_n)
            (m != '0) |-> m[r] && ((m & ((CPU_N'(1) << r) - CPU_N'(1))) == '0));

        // R6: empty mask routes to CPU 0
        a_r6_empty_route_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (m == '0) |-> (r == '0));
    end
endmodule

bind itr_target_bank itr_target_bank_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .priv_targets (priv_targets),
    .route_cpu    (route_cpu),
    .all_masks    (all_masks)
);

// File: tb/tb_itr_target_bank.sv
module tb_itr_target_bank;
    localparam int NUM_IRQ = 64;
    localparam int ADDR_W  = 8;
    localparam int WORDS   = NUM_IRQ / 4;
    localparam int NSH     = NUM_IRQ - 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_wr, bus_rd;
    logic [3:0]        bus_be;
    logic [31:0]       bus_wdata, bus_rdata;
    logic [255:0]      priv_targets;
    logic [NSH*3-1:0]  route_cpu;

    logic [7:0] exp_mask [NUM_IRQ];
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    itr_target_bank #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .priv_targets(priv_targets), .route_cpu(route_cpu)
    );

    function automatic logic [2:0] ref_route(input logic [7:0] m);
        for (int b = 0; b < 8; b++) if (m[b]) return 3'(b);
        return 3'd0;
    endfunction

    function automatic logic [31:0] ref_word(input int w);
        if (w >= WORDS) return 32'h0;
        return {exp_mask[4*w+3], exp_mask[4*w+2], exp_mask[4*w+1], exp_mask[4*w]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_write(input int a, input logic [3:0] be, input logic [31:0] d);
        for (int i = 0; i < 4; i++)
            if (be[i] && a < WORDS && (4*a+i) >= 32) exp_mask[4*a+i] = d[8*i +: 8];
    endtask

    task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, be, d);
    endtask

    task automatic rd_check(input string req, input int a);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, ref_word(a));
    endtask

    task automatic check_routes(input string req);
        for (int k = 0; k < NSH; k++)
            check(req, 32'(route_cpu[3*k +: 3]), 32'(ref_route(exp_mask[32+k])));
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] old;
        void'($urandom(32'd4242));
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
        for (int i = 0; i < 8; i++) priv_targets[32*i +: 32] = $urandom;
        for (int i = 0; i < NUM_IRQ; i++) exp_mask[i] = (i < 32) ? priv_targets[8*i +: 8] : 8'h0;
        repeat (3) @(negedge clk);
        check("R1 rdata", bus_rdata, 32'h0);
        check_routes("R1 routes");
        rst_n = 1'b1;
        rd_check("R1 shared word", 8);

        // R4: private words read the input and ignore writes
        for (int w = 0; w < 8; w++) rd_check("R4 private read", w);
        wr(3, 4'hF, 32'hFFFF_FFFF);
        wr(7, 4'h2, 32'h0000_5A00);
        rd_check("R4 private write ignored", 3);
        rd_check("R4 private write ignored", 7);

        // R2 R3: lane mapping and partial strobes
        wr(8, 4'h1, 32'hA1B2_C3D4);
        rd_check("R3 byte lane0", 8);
        wr(8, 4'hF, 32'h8040_2010);
        rd_check("R2 word", 8);
        wr(8, 4'h4, 32'h00FF_0000);
        rd_check("R3 byte lane2", 8);
        wr(9, 4'hA, 32'h1100_2200);
        rd_check("R2 R3 mixed lanes", 9);
        check_routes("R5 R9 after lanes");

        // R5 R6: lowest bit and empty mask
        wr(10, 4'hF, 32'h0080_0601);
        check_routes("R5 R6 R9 directed");
        wr(10, 4'hF, 32'hFF00_0000);
        check_routes("R6 empty");
        rd_check("R6 empty readback", 10);

        // R8: out-of-range words
        wr(WORDS, 4'hF, 32'hFFFF_FFFF);
        wr(200, 4'hF, 32'h1234_5678);
        rd_check("R8 oor read", WORDS);
        rd_check("R8 oor read", 255);
        for (int w = 0; w < WORDS; w++) rd_check("R8 oor write ignored", w);

        // R7: read and write of one word in the same cycle
        old = ref_word(11);
        @(negedge clk);
        bus_addr = 8'd11; bus_be = 4'hF; bus_wdata = 32'h0102_0408; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        model_write(11, 4'hF, 32'h0102_0408);
        check("R7 read before write", bus_rdata, old);
        repeat (2) @(negedge clk);
        check("R7 hold", bus_rdata, old);
        rd_check("R7 new value", 11);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int a;
            logic [3:0] be;
            logic [31:0] d;
            logic r;
            a = int'($urandom_range(0, WORDS + 3));
            be = 4'($urandom);
            d = $urandom;
            if ($urandom_range(0, 3) == 0) d = d & 32'h0101_0000;
            r = 1'($urandom);
            old = ref_word(a);
            @(negedge clk);
            bus_addr = ADDR_W'(a); bus_be = be; bus_wdata = d; bus_wr = 1'b1; bus_rd = r;
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b0;
            model_write(a, be, d);
            if (r) check("R7 R2 random read", bus_rdata, old);
            check_routes("R5 R6 random");
        end
        for (int w = 0; w < WORDS + 2; w++) rd_check("R2 R3 R8 final sweep", w);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule